// File: doc/BRIEF.md
# Lockable Fault-to-Break Router

This block takes four internal fault event lines and turns them into one timer break request. When the system fails, timers can then force their outputs into a known safe state. Software arms each fault source through a small register port. A source's route, once armed, stays armed until the next reset. A crashed or runaway program cannot disarm the safety path.

Beside the routing sits a sticky flag that records any RAM parity error. It is set whether or not that source is routed to break, and software clears it by writing 1 to its bit. The break output is the registered OR of every armed source whose fault line is high.

Register layout (single word, `DATA_W` bits):

- bit 0 arms the supply voltage detector source.
- bit 1 arms the processor lockup source.
- bit 2 arms the RAM parity source.
- bit 3 arms the flash ECC source.
- bit 4 is the parity flag.
- All higher bits read 0.

Top module: `fault_brk_route`

## Requirements
- R1: After reset, all four route enables, the parity flag and `brk_o` are 0.
- R2: A write with bit k of `wdata_i` at 1 (k in 0..3) sets route enable k. The new value shows in `rdata_o[k]` from the cycle after the write.
- R3: A set route enable ignores all later writes, including writes of 0, until reset.
- R4: `brk_o` is 1 in the cycle after an edge at which some fault line `fault_i[k]` is 1 while route enable k is already set.
- R5: `brk_o` stays 0 in the cycle after an edge at which no armed source has its fault line high. This holds even if unarmed sources are faulting.
- R6: A 1 on `fault_i[2]` (RAM parity) sets the parity flag, `rdata_o[4]`, from the next cycle. This happens whether or not route enable 2 is set.
- R7: A write with `wdata_i[4]` at 1 clears the parity flag. A write with `wdata_i[4]` at 0 leaves it unchanged.
- R8: When a clear write and a parity fault occur in the same cycle, the flag ends up set.
- R9: `rdata_o` bits above 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data: enables in [3:0], parity flag in [4] |
| fault_i | input | N_SRC | Fault events: 0 voltage, 1 lockup, 2 RAM parity, 3 flash ECC |
| brk_o | output | 1 | Registered break request to the timers |

## Verification
The hardest states to reach are collisions. One is a clear write landing in the same cycle as a new parity event. Another is a write of 0 landing on an already-locked enable while that source is faulting. The stimulus first arms sources one at a time. It then drives combined cycles that hit the flag with a set and a clear together, and that rewrite locked bits with zeros while faults are active. A reference model tracks the lock and flag state so that each expected read value and break value follows from the requirements alone.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam int unsigned N_SRC      = 4;
  localparam int unsigned PARITY_IDX = 2;
  localparam int unsigned FLAG_BIT   = N_SRC;

  typedef enum logic [1:0] {
    SRC_VOLT   = 2'd0,
    SRC_LOCKUP = 2'd1,
    SRC_PARITY = 2'd2,
    SRC_ECC    = 2'd3
  } fault_src_e;
endpackage

// File: rtl/fbr_lock_bank.sv
module fbr_lock_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] en_o
);
  for (genvar k = 0; k < N; k++) begin : g_lock
    // write-once: only a 1 can land, nothing clears it but reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 en_o[k] <= 1'b0;
      else if (wr_en_i && set_i[k]) en_o[k] <= 1'b1;
    end
  end
endmodule

// File: rtl/fbr_sticky_flag.sv
module fbr_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set beats clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/fbr_break_merge.sv
module fbr_break_merge #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] fault_i,
  input  logic [N-1:0] en_i,
  output logic         brk_o
);
  logic brk_d;
  assign brk_d = |(fault_i & en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_o <= 1'b0;
    else         brk_o <= brk_d;
  end
endmodule

// File: rtl/fault_brk_route.sv
module fault_brk_route
  import fbr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  fault_i,
  output logic              brk_o
);
  localparam int unsigned PAD_W = DATA_W - N_SRC - 1;

  logic [N_SRC-1:0] en_q;
  logic             par_flag_q;

  fbr_lock_bank #(.N(N_SRC)) i_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .set_i   (wdata_i[N_SRC-1:0]),
    .en_o    (en_q)
  );

  fbr_sticky_flag i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fault_i[PARITY_IDX]),
    .clr_i  (wr_en_i && wdata_i[FLAG_BIT]),
    .flag_o (par_flag_q)
  );

  fbr_break_merge #(.N(N_SRC)) i_brk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault_i (fault_i),
    .en_i    (en_q),
    .brk_o   (brk_o)
  );

  assign rdata_o = {{PAD_W{1'b0}}, par_flag_q, en_q};
endmodule

// File: rtl/fault_brk_route_chk.sv
module fault_brk_route_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [3:0]        fault_i,
  input logic              brk_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> (rdata_o == '0 && !brk_o)); // R1
  AST_ARM_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i[0]) |=> rdata_o[0]); // R2
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[3:0] == 4'hF) |=> (rdata_o[3:0] == 4'hF)); // R3
  AST_LOCK_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[0] |=> rdata_o[0]); // R3
  AST_BRK_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(fault_i & rdata_o[3:0])) |=> brk_o); // R4
  AST_BRK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(fault_i & rdata_o[3:0])) |=> !brk_o); // R5
  AST_PAR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i[2] |=> rdata_o[4]); // R6 R8
  AST_PAR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wdata_i[4] && !fault_i[2]) |=> !rdata_o[4]); // R7
  AST_PAD_ZERO: assert property (@(posedge clk_i) rdata_o[DATA_W-1:5] == '0); // R9
endmodule

bind fault_brk_route fault_brk_route_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .fault_i (fault_i),
  .brk_o   (brk_o)
);

// File: tb/test_fault_brk_route.sv
module test_fault_brk_route;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DATA_W     = 8;

  typedef struct {
    logic [DATA_W-1:0] rdata;
    logic              brk;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [3:0]        fault = '0;
  logic              brk;

  int   n_chk = 0;
  int   n_err = 0;
  exp_t sb_q[$];
  logic [3:0] en_m = '0;
  logic       flag_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_brk_route #(.DATA_W(DATA_W)) i_fault_brk_route (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .fault_i (fault),
    .brk_o   (brk)
  );

  // driver: drive one cycle at negedge, push the model's prediction
  task automatic step(input logic w, input logic [DATA_W-1:0] d,
                      input logic [3:0] f, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = w; wdata = d; fault = f;
    e.brk = |(f & en_m);
    if (w) en_m = en_m | d[3:0];
    if (f[2]) flag_m = 1'b1;
    else if (w && d[4]) flag_m = 1'b0;
    e.rdata = {{(DATA_W-5){1'b0}}, flag_m, en_m};
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (rdata !== e.rdata || brk !== e.brk) begin
          n_err++;
          $display("FAIL %s: rdata=%h brk=%b expected rdata=%h brk=%b",
                   e.tag, rdata, brk, e.rdata, e.brk);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_err++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    n_chk++;
    if (rdata !== '0 || brk !== 1'b0) begin
      n_err++;
      $display("FAIL R1: rdata=%h brk=%b expected rdata=00 brk=0", rdata, brk);
    end
    @(negedge clk); rst_n = 1'b1;

    step(0, 8'h00, 4'hB, "R5 unarmed faults");
    step(0, 8'h00, 4'h4, "R6 parity unrouted");
    step(0, 8'h00, 4'h0, "R6 flag sticky");
    step(1, 8'h10, 4'h0, "R7 w1c clear");
    step(1, 8'h00, 4'h4, "R6 re-set");
    step(1, 8'h00, 4'h0, "R7 write 0 keeps");
    step(1, 8'h10, 4'h4, "R8 set beats clear");
    step(1, 8'h01, 4'h0, "R2 arm voltage");
    step(0, 8'h00, 4'h1, "R4 voltage fault");
    step(0, 8'h00, 4'h2, "R5 lockup unarmed");
    step(1, 8'h00, 4'h1, "R3 zero write on locked");
    step(0, 8'h00, 4'h0, "R4 break drops");
    step(1, 8'h08, 4'h8, "R2 arm ecc same cycle");
    step(0, 8'h00, 4'h8, "R4 ecc fault");
    step(1, 8'hE6, 4'h4, "R9 pad write");
    step(1, 8'h00, 4'h2, "R3 lock after zero write");
    step(1, 8'h10, 4'h0, "R7 clear");
    step(0, 8'h00, 4'h0, "R3 idle hold");
    @(negedge clk); wr_en = 1'b0; wdata = '0; fault = '0;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule